// File: doc/BRIEF.md
# Legacy Memory Window Route Decoder

This block decides, for each memory access in the first megabyte, whether the access is served by local DRAM or passed on to the external bus. It looks at the access address, whether the access is a read or a write, and a packed set of seven attribute bytes. The bytes come from a register file kept elsewhere. The window from 0xC0000 to 0xFFFFF is split into twelve 16 KB segments (0xC0000 to 0xEFFFF) and one 64 KB top region (0xF0000 to 0xFFFFF). Each of these areas is governed by one 4-bit attribute nibble. Of each nibble only the two low bits carry meaning: bit 0 routes reads to DRAM and bit 1 routes writes to DRAM.

Addresses outside the window always go to DRAM. The decision is registered once, so the select for an access that is presented in one cycle appears after the next rising clock edge. A change of attribute bytes acts on the first access that is presented together with the new value. No pipeline holds a stale copy of the attributes.

Top module: `shadow_route_decoder`

## Requirements
- R1: For a read inside the window, `route_int` is 1 (DRAM) exactly when bit 0 of the governing nibble is 1, and 0 (external bus) otherwise.
- R2: For a write inside the window, `route_int` is 1 exactly when bit 1 of the governing nibble is 1, and 0 otherwise.
- R3: Accesses in 0xF0000 to 0xFFFFF are governed by `attr_bytes[7:4]` (the upper nibble of byte 0). The lower nibble `attr_bytes[3:0]` has no effect on any access.
- R4: Accesses in 0xC0000 to 0xEFFFF fall into segment s = (address - 0xC0000) / 0x4000, for s from 0 to 11. Segment s is governed by byte k = 1 + s/2 at `attr_bytes[8k+7:8k]`. An even s uses the low nibble of that byte and an odd s uses the high nibble. The first segment (0xC0000) is governed by `attr_bytes[11:8]` and the last (0xEC000) by `attr_bytes[55:52]`.
- R5: Bits 3 and 2 of every nibble have no effect on routing.
- R6: Addresses below 0xC0000, or at 0x100000 and above, give `route_int` = 1 for reads and writes, whatever the attribute bytes hold.
- R7: `route_int` shows the decision for the inputs sampled at the previous rising edge. An attribute change applies to the first access that is presented with the new value.
- R8: While `rst` is high at a rising edge, `route_int` becomes 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 32 | Byte address of the current access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| attr_bytes | input | 56 | Seven attribute bytes; byte k at bits [8k+7:8k] |
| route_int | output | 1 | 1: access goes to DRAM; 0: access goes to the external bus |

## Verification
A wrong segment index or a wrong nibble choice shows up as a wrong `route_int` on the very next cycle. It shows only for accesses in the affected 16 KB slice and only when the two candidate nibbles differ. For this reason the stimulus draws the attribute bytes at random for each access, and the addresses cluster around the window. Swapped read and write bits show up the same way, one cycle later, whenever a nibble has unequal low bits. Directed cases cover the window edges, the unused nibble bits, the ignored low nibble of byte 0, and the ordering when an attribute changes between back-to-back accesses.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;

  typedef enum logic [1:0] {
    ATTR_BOTH_EXT = 2'd0,
    ATTR_RD_INT   = 2'd1,
    ATTR_WR_INT   = 2'd2,
    ATTR_BOTH_INT = 2'd3
  } attr_code_e;

  localparam int NIB_W       = 4;
  localparam int CODE_W      = 2;
  localparam int TOP_NIB_LSB = 4;

endpackage

// File: rtl/shadow_region_map.sv
module shadow_region_map #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] WIN_BASE  = 32'h000C_0000,
  parameter logic [31:0] TOP_BASE  = 32'h000F_0000,
  parameter logic [31:0] WIN_END   = 32'h0010_0000,
  parameter int          SEG_SHIFT = 14,
  parameter int          N_SEG     = 12,
  parameter int          IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_top,
  output logic              hit_seg,
  output logic [IDX_W-1:0]  seg_idx
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] TOPB_A = ADDR_W'(TOP_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(WIN_END);

  logic [ADDR_W-1:0] seg_full;

  always_comb begin
    hit_top  = (addr >= TOPB_A) && (addr < END_A);
    hit_seg  = (addr >= BASE_A) && (addr < TOPB_A);
    seg_full = (addr - BASE_A) >> SEG_SHIFT;
    seg_idx  = seg_full[IDX_W-1:0];
  end

  // the two areas never overlap
  assert_region_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_top, hit_seg}));

  // a segment hit always lands on one of the defined segments
  assert_seg_bound_R4: assert property (@(posedge clk) disable iff (rst)
    hit_seg |-> (seg_full < ADDR_W'(N_SEG)));

endmodule

// File: rtl/shadow_attr_pick.sv
module shadow_attr_pick
  import shadow_route_pkg::*;
#(
  parameter int N_ATTR = 7,
  parameter int N_SEG  = 12,
  parameter int IDX_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [8*N_ATTR-1:0] attr_bytes,
  input  logic                hit_top,
  input  logic                hit_seg,
  input  logic [IDX_W-1:0]    seg_idx,
  output attr_code_e          code
);

  localparam int SLOTS = 2**IDX_W;

  logic [CODE_W-1:0] seg_code [SLOTS];
  logic [CODE_W-1:0] top_code;
  logic              unused_attr;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      if (g < N_SEG) begin : g_live
        localparam int LSB = 8*(1 + g/2) + NIB_W*(g%2);
        assign seg_code[g] = attr_bytes[LSB +: CODE_W];
      end else begin : g_pad
        assign seg_code[g] = CODE_W'(ATTR_BOTH_INT);
      end
    end
  endgenerate

  assign top_code    = attr_bytes[TOP_NIB_LSB +: CODE_W];
  assign unused_attr = ^attr_bytes;

  always_comb begin
    if (hit_top)      code = attr_code_e'(top_code);
    else if (hit_seg) code = attr_code_e'(seg_code[seg_idx]);
    else              code = ATTR_BOTH_INT;
  end

  // top region follows the upper nibble of byte 0
  assert_top_nibble_R3: assert property (@(posedge clk) disable iff (rst)
    hit_top |-> (code == attr_code_e'(attr_bytes[5:4])));

  // first segment follows the low nibble of byte 1
  assert_first_seg_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_seg && seg_idx == '0) |-> (code == attr_code_e'(attr_bytes[9:8])));

endmodule

// File: rtl/shadow_route_rule.sv
module shadow_route_rule
  import shadow_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  attr_code_e code,
  input  logic       is_write,
  output logic       to_dram
);

  logic [CODE_W-1:0] code_bits;

  always_comb begin
    code_bits = code;
    to_dram   = is_write ? code_bits[1] : code_bits[0];
  end

  assert_both_int_R1: assert property (@(posedge clk) disable iff (rst)
    (code == ATTR_BOTH_INT) |-> to_dram);

  assert_both_ext_R2: assert property (@(posedge clk) disable iff (rst)
    (code == ATTR_BOTH_EXT) |-> !to_dram);

  assert_rd_only_R1: assert property (@(posedge clk) disable iff (rst)
    (code == ATTR_RD_INT) |-> (to_dram == !is_write));

endmodule

// File: rtl/shadow_route_decoder.sv
module shadow_route_decoder
  import shadow_route_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          N_ATTR    = 7,
  parameter logic [31:0] WIN_BASE  = 32'h000C_0000,
  parameter logic [31:0] TOP_BASE  = 32'h000F_0000,
  parameter logic [31:0] WIN_END   = 32'h0010_0000,
  parameter int          SEG_SHIFT = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic                acc_write,
  input  logic [8*N_ATTR-1:0] attr_bytes,
  output logic                route_int
);

  localparam int N_SEG = int'((TOP_BASE - WIN_BASE) >> SEG_SHIFT);
  localparam int IDX_W = $clog2(N_SEG);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(WIN_END);

  logic             hit_top;
  logic             hit_seg;
  logic [IDX_W-1:0] seg_idx;
  attr_code_e       code;
  logic             to_dram;

  shadow_region_map #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .TOP_BASE(TOP_BASE),
    .WIN_END(WIN_END), .SEG_SHIFT(SEG_SHIFT), .N_SEG(N_SEG), .IDX_W(IDX_W)
  ) u_map (
    .clk(clk), .rst(rst), .addr(acc_addr),
    .hit_top(hit_top), .hit_seg(hit_seg), .seg_idx(seg_idx)
  );

  shadow_attr_pick #(
    .N_ATTR(N_ATTR), .N_SEG(N_SEG), .IDX_W(IDX_W)
  ) u_pick (
    .clk(clk), .rst(rst), .attr_bytes(attr_bytes),
    .hit_top(hit_top), .hit_seg(hit_seg), .seg_idx(seg_idx), .code(code)
  );

  shadow_route_rule u_rule (
    .clk(clk), .rst(rst), .code(code), .is_write(acc_write), .to_dram(to_dram)
  );

  always_ff @(posedge clk) begin
    if (rst) route_int <= 1'b1;
    else     route_int <= to_dram;
  end

  assert_reset_dram_R8: assert property (@(posedge clk)
    rst |=> route_int);

  assert_outside_dram_R6: assert property (@(posedge clk) disable iff (rst)
    ((acc_addr < LO_A) || (acc_addr >= HI_A)) |=> route_int);

endmodule

// File: tb/test_shadow_route_decoder.sv
`timescale 1ns/1ps
module test_shadow_route_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_write = 1'b0;
  logic [55:0] attr_bytes = 56'h0;
  logic        route_int;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  shadow_route_decoder i_shadow_route_decoder (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_write(acc_write),
    .attr_bytes(attr_bytes), .route_int(route_int)
  );

  function automatic logic model(logic [31:0] a, logic w, logic [55:0] b);
    logic [3:0] nib;
    int s;
    if (a >= 32'hF0000 && a < 32'h100000) nib = b[7:4];
    else if (a >= 32'hC0000 && a < 32'hF0000) begin
      s   = int'((a - 32'hC0000) >> 14);
      nib = b[8*(1 + s/2) + 4*(s%2) +: 4];
    end else return 1'b1;
    return w ? nib[1] : nib[0];
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: route_int=%0b expected %0b (addr=%h wr=%0b attr=%h)",
               tag, act, exp, acc_addr, acc_write, attr_bytes);
    end
  endtask

  // called at a falling edge; result is checked at the next falling edge
  task automatic step(input logic [31:0] a, input logic w, input logic [55:0] b,
                      input string tag);
    acc_addr = a; acc_write = w; attr_bytes = b;
    @(negedge clk);
    check(route_int, model(a, w, b), tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R8: reset forces DRAM even for a window address coded external
    acc_addr = 32'hF0000; acc_write = 1'b0; attr_bytes = 56'h0;
    @(negedge clk); @(negedge clk);
    check(route_int, 1'b1, "R8 reset");
    @(negedge clk);
    check(route_int, 1'b1, "R8 reset held");
    rst = 1'b0;

    // R6 window edges with everything external
    step(32'h000BFFFF, 1'b0, 56'h0, "R6 below window");
    step(32'h00100000, 1'b1, 56'h0, "R6 above window");
    step(32'h000C0000, 1'b0, 56'h0, "R4 first byte external");
    step(32'h000EFFFF, 1'b1, 56'h0, "R4 last byte external");
    step(32'h000FFFFF, 1'b0, 56'h0, "R3 top external");
    step(32'h80000000, 1'b0, 56'h0, "R6 high address");
    // R3: low nibble of byte 0 ignored
    step(32'h000F8000, 1'b0, 56'h0F, "R3 low nibble ignored");
    step(32'h000F8000, 1'b1, 56'h0F, "R3 low nibble ignored wr");
    // R1 / R2 code mapping on the top region
    step(32'h000F0000, 1'b0, 56'h10, "R1 read internal");
    step(32'h000F0000, 1'b1, 56'h10, "R2 write external");
    step(32'h000F0000, 1'b0, 56'h20, "R1 read external");
    step(32'h000F0000, 1'b1, 56'h20, "R2 write internal");
    // R5: upper nibble bits ignored
    step(32'h000FFFFF, 1'b1, 56'hC0, "R5 high bits ignored");
    step(32'h000FFFFF, 1'b0, 56'hC0, "R5 high bits ignored rd");
    step(32'h000C0000, 1'b0, 56'h0C_00, "R5 segment high bits");
    // R4: last byte holds two segments
    step(32'h000E8000, 1'b0, 56'h31_00_00_00_00_00_00, "R4 seg10 read");
    step(32'h000E8000, 1'b1, 56'h31_00_00_00_00_00_00, "R4 seg10 write");
    step(32'h000EC000, 1'b1, 56'h31_00_00_00_00_00_00, "R4 seg11 write");
    step(32'h000E7FFF, 1'b0, 56'h31_00_00_00_00_00_00, "R4 seg9 read");
    step(32'h000C4000, 1'b0, 56'h00_00_00_00_00_10_00, "R4 seg1 high nibble");
    step(32'h000C3FFF, 1'b0, 56'h00_00_00_00_00_10_00, "R4 seg0 low nibble");
    // R7: back-to-back attribute change at a fixed address
    step(32'h000C4000, 1'b0, 56'h00_00_00_00_00_10_00, "R7 before change");
    step(32'h000C4000, 1'b0, 56'h00_00_00_00_00_00_00, "R7 after change");
    step(32'h000C4000, 1'b0, 56'h00_00_00_00_00_30_00, "R7 change back");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      logic [55:0] b;
      int sel;
      sel = int'($urandom % 4);
      case (sel)
        0: a = 32'h000C0000 + ($urandom % 32'h40000);
        1: a = 32'h000A0000 + ($urandom % 32'h80000);
        2: a = 32'h000C0000 + (($urandom % 17) << 14) - ($urandom % 2);
        default: a = $urandom;
      endcase
      b = {$urandom, $urandom};
      step(a, 1'($urandom), b, "R1 R2 R3 R4 R6 R7 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule